// File: doc/BRIEF.md
# Boot Memory-Map and Slave-Release Sequencer

This block controls the address map and the reset of a two-processor controller during start-up. One processor is the host DSP, which boots itself from EPROM. The other is a slave microcontroller, which runs from a program SRAM that the host fills with code. After any reset, the shared SRAM is decoded high in the host address space. The slave is held in reset, and the host's boot-select interrupt line is driven so that the host performs an 8-bit load from the EPROM window.

When its own load is complete, the host writes a remap bit in a control address. From the next clock, the shared SRAM decodes from address zero and the boot-select line drops. While the slave is still in reset, the host can reach the slave's program store through a dedicated window, so it can clear the store and then copy code into it. A second control write releases the slave from reset. In the same cycle, ownership of the program store passes to the slave, and the host window stops decoding. Both steps are one-way until the next reset.

Top module: `boot_map_seq`

## Requirements
- R1: On a clock edge with `rst_n` low, the outputs become `slave_rst_n`=0, `boot_int`=1 and `pstore_own_slave`=0 by the next sample.
- R2: Before remap, `sram_cs` asserts for addresses 0xF00000 to 0xF07FFF and for no address below 0x008000.
- R3: `eprom_cs[k]` asserts for addresses 0x400000+k·0x10000 through 0x40FFFF+k·0x10000 (k = 0, 1), in every state.
- R4: A write to the control address 0x810000 with data bit 0 (remap) set moves the shared SRAM to 0x000000–0x007FFF from the next cycle, stops decoding it at 0xF00000, and deasserts `boot_int`.
- R5: While the slave is in reset, `pstore_cs` asserts for 0x800000 to 0x80FFFF and `pstore_own_slave` is 0, so the host owns the program store.
- R6: After remap, a control write with data bit 1 (release) set drives `slave_rst_n`=1 and `pstore_own_slave`=1 from the next cycle. From then on, `pstore_cs` never asserts.
- R7: A release bit written before remap has taken effect is ignored. This includes a single write with both bits set, which performs the remap only.
- R8: Control writes with a bit cleared do not undo a completed step. Writes to any address other than 0x810000 do not change the state.
- R9: At most one chip select is active at a time, and none is active while `host_strb` is low.
- R10: A reset from any state (loading or running) restores the boot map and slave reset by the next sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_addr | input | 24 | Host word address |
| host_strb | input | 1 | Host access strobe |
| host_we | input | 1 | Host write strobe |
| host_wdata | input | 2 | Control data: bit 0 remap, bit 1 release slave |
| sram_cs | output | 1 | Shared SRAM chip select |
| eprom_cs | output | 2 | EPROM chip selects, one per device |
| pstore_cs | output | 1 | Host select of the slave program store |
| slave_rst_n | output | 1 | Slave reset, active low |
| boot_int | output | 1 | Host boot-select interrupt, active high |
| pstore_own_slave | output | 1 | Program-store owner: 0 host, 1 slave |

## Verification
In each of the three phases (boot, loaded, running), the decoder is swept over every region base plus the offsets 0, 1, 0x7FFF, 0x8000, 0xFFFF, 0x10000 and −1. These points separate each region's first and last word from its neighbours. They also distinguish a 32K SRAM window from a 64K window, and show whether the high or low SRAM copy is live. The control path is tried with release-only, both-bits, cleared-bit and misaddressed writes, which tells an ordering-aware sequencer from one that just latches bits. Resets are applied in the loaded and running phases to separate a full restore from a partial one.

// File: rtl/boot_map_pkg.sv
// Shared types and control-bit positions for the boot map sequencer.
package boot_map_pkg;
    // Boot phases: high map, low map with slave held, slave running.
    typedef enum logic [1:0] {
        ST_BOOT = 2'd0,
        ST_LOAD = 2'd1,
        ST_RUN  = 2'd2
    } boot_state_e;

    localparam int CTRL_W       = 2;
    localparam int CTRL_REMAP   = 0;
    localparam int CTRL_RELEASE = 1;
endpackage

// File: rtl/boot_seq_fsm.sv
// Phase sequencer. It moves BOOT -> LOAD on a remap write and LOAD -> RUN
// on a release write. It never moves backwards except through reset.
// Assumes ctrl_wr is a single-cycle qualified write to the control address.
module boot_seq_fsm
    import boot_map_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr,
    input  logic [CTRL_W-1:0] ctrl_bits,
    output logic              map_low,
    output logic              slave_run,
    output logic              boot_sel
);
    boot_state_e state_q, state_d;

    // Next-phase selection; a release is honoured only once in LOAD.
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_BOOT: if (ctrl_wr && ctrl_bits[CTRL_REMAP])   state_d = ST_LOAD;
            ST_LOAD: if (ctrl_wr && ctrl_bits[CTRL_RELEASE]) state_d = ST_RUN;
            ST_RUN:  state_d = ST_RUN;
            default: state_d = ST_BOOT;
        endcase
    end

    // Phase register with synchronous reset to the boot phase.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_BOOT;
        else        state_q <= state_d;
    end

    // Decode phase into map and reset controls.
    always_comb begin
        map_low   = (state_q != ST_BOOT);
        slave_run = (state_q == ST_RUN);
        boot_sel  = (state_q == ST_BOOT);
    end
endmodule

// File: rtl/boot_addr_dec.sv
// Host address decoder. Produces chip selects for the shared SRAM (high or
// low copy, depending on map_low), for each EPROM, and for the slave program
// store (host side, only while the slave is held). It also flags control writes.
// Assumes region bases are aligned to their own sizes.
module boot_addr_dec #(
    parameter int          ADDR_W         = 24,
    parameter int          SRAM_AW        = 15,
    parameter int unsigned SRAM_BOOT_BASE = 32'hF00000,
    parameter int unsigned SRAM_RUN_BASE  = 32'h000000,
    parameter int          EPROM_AW       = 16,
    parameter int          N_EPROM        = 2,
    parameter int unsigned EPROM_BASE     = 32'h400000,
    parameter int          PSTORE_AW      = 16,
    parameter int unsigned PSTORE_BASE    = 32'h800000,
    parameter int unsigned CTRL_ADDR      = 32'h810000
) (
    input  logic [ADDR_W-1:0]  host_addr,
    input  logic               host_strb,
    input  logic               host_we,
    input  logic               map_low,
    input  logic               slave_run,
    output logic               sram_cs,
    output logic [N_EPROM-1:0] eprom_cs,
    output logic               pstore_cs,
    output logic               ctrl_wr
);
    localparam logic [ADDR_W-1:0] BOOT_B = ADDR_W'(SRAM_BOOT_BASE);
    localparam logic [ADDR_W-1:0] RUN_B  = ADDR_W'(SRAM_RUN_BASE);
    localparam logic [ADDR_W-1:0] PS_B   = ADDR_W'(PSTORE_BASE);
    localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);
    localparam int unsigned       EP_SZ  = 1 << EPROM_AW;

    logic in_sram_hi, in_sram_lo, in_ps;

    // Region hits for the SRAM copies and the program-store window.
    always_comb begin
        in_sram_hi = (host_addr >> SRAM_AW)   == (BOOT_B >> SRAM_AW);
        in_sram_lo = (host_addr >> SRAM_AW)   == (RUN_B  >> SRAM_AW);
        in_ps      = (host_addr >> PSTORE_AW) == (PS_B   >> PSTORE_AW);
    end

    // SRAM, program-store and control selects qualified by strobe and phase.
    always_comb begin
        sram_cs   = host_strb && (map_low ? in_sram_lo : in_sram_hi);
        pstore_cs = host_strb && in_ps && !slave_run;
        ctrl_wr   = host_strb && host_we && (host_addr == CTRL_A);
    end

    // One decoder per EPROM device, stacked from EPROM_BASE.
    for (genvar k = 0; k < N_EPROM; k++) begin : g_eprom
        localparam logic [ADDR_W-1:0] THIS_B = ADDR_W'(EPROM_BASE + k * EP_SZ);
        assign eprom_cs[k] = host_strb &&
                             ((host_addr >> EPROM_AW) == (THIS_B >> EPROM_AW));
    end
endmodule

// File: rtl/boot_map_seq.sv
// Top of the boot map sequencer. It connects the phase sequencer to the
// address decoder and drives the slave reset, the boot-select interrupt and
// the program-store ownership select. Reset is synchronous and active low.
module boot_map_seq
    import boot_map_pkg::*;
#(
    parameter int          ADDR_W         = 24,
    parameter int          SRAM_AW        = 15,
    parameter int unsigned SRAM_BOOT_BASE = 32'hF00000,
    parameter int unsigned SRAM_RUN_BASE  = 32'h000000,
    parameter int          EPROM_AW       = 16,
    parameter int          N_EPROM        = 2,
    parameter int unsigned EPROM_BASE     = 32'h400000,
    parameter int          PSTORE_AW      = 16,
    parameter int unsigned PSTORE_BASE    = 32'h800000,
    parameter int unsigned CTRL_ADDR      = 32'h810000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  host_addr,
    input  logic               host_strb,
    input  logic               host_we,
    input  logic [CTRL_W-1:0]  host_wdata,
    output logic               sram_cs,
    output logic [N_EPROM-1:0] eprom_cs,
    output logic               pstore_cs,
    output logic               slave_rst_n,
    output logic               boot_int,
    output logic               pstore_own_slave
);
    logic map_low, slave_run, ctrl_wr;

    boot_seq_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl_wr   (ctrl_wr),
        .ctrl_bits (host_wdata),
        .map_low   (map_low),
        .slave_run (slave_run),
        .boot_sel  (boot_int)
    );

    boot_addr_dec #(
        .ADDR_W         (ADDR_W),
        .SRAM_AW        (SRAM_AW),
        .SRAM_BOOT_BASE (SRAM_BOOT_BASE),
        .SRAM_RUN_BASE  (SRAM_RUN_BASE),
        .EPROM_AW       (EPROM_AW),
        .N_EPROM        (N_EPROM),
        .EPROM_BASE     (EPROM_BASE),
        .PSTORE_AW      (PSTORE_AW),
        .PSTORE_BASE    (PSTORE_BASE),
        .CTRL_ADDR      (CTRL_ADDR)
    ) u_dec (
        .host_addr (host_addr),
        .host_strb (host_strb),
        .host_we   (host_we),
        .map_low   (map_low),
        .slave_run (slave_run),
        .sram_cs   (sram_cs),
        .eprom_cs  (eprom_cs),
        .pstore_cs (pstore_cs),
        .ctrl_wr   (ctrl_wr)
    );

    // Slave reset release and store ownership switch together.
    always_comb begin
        slave_rst_n      = slave_run;
        pstore_own_slave = slave_run;
    end
endmodule

// File: rtl/boot_map_seq_chk.sv
// Assertion checker for boot_map_seq, attached by bind below. It observes
// only the top-level ports.
module boot_map_seq_chk #(
    parameter int ADDR_W  = 24,
    parameter int SRAM_AW = 15,
    parameter int N_EPROM = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic [ADDR_W-1:0]  host_addr,
    input logic               host_strb,
    input logic               sram_cs,
    input logic [N_EPROM-1:0] eprom_cs,
    input logic               pstore_cs,
    input logic               slave_rst_n,
    input logic               boot_int,
    input logic               pstore_own_slave
);
    // R1, R10: a reset edge restores the boot controls.
    a_r10_reset_restores: assert property (@(posedge clk)
        !rst_n |=> (!slave_rst_n && boot_int && !pstore_own_slave));

    // R9: selects are mutually exclusive.
    a_r9_onehot_cs: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sram_cs, eprom_cs, pstore_cs}));

    // R9: no select without a strobe.
    a_r9_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !host_strb |-> !(sram_cs || (|eprom_cs) || pstore_cs));

    // R7: the slave never runs while the boot map is still in force.
    a_r7_no_early_release: assert property (@(posedge clk) disable iff (!rst_n)
        boot_int |-> !slave_rst_n);

    // R4, R8: once boot-select drops it stays low until reset.
    a_r8_boot_one_way: assert property (@(posedge clk) disable iff (!rst_n)
        !boot_int |=> !boot_int);

    // R6, R8: a released slave stays released.
    a_r6_run_one_way: assert property (@(posedge clk) disable iff (!rst_n)
        slave_rst_n |=> slave_rst_n);

    // R6: the host cannot select the store once the slave owns it.
    a_r6_store_locked: assert property (@(posedge clk) disable iff (!rst_n)
        pstore_own_slave |-> !pstore_cs);

    // R4: after remap, a strobed low address selects the SRAM.
    a_r4_low_sram: assert property (@(posedge clk) disable iff (!rst_n)
        (!boot_int && host_strb && ((host_addr >> SRAM_AW) == '0)) |-> sram_cs);
endmodule

bind boot_map_seq boot_map_seq_chk #(
    .ADDR_W  (ADDR_W),
    .SRAM_AW (SRAM_AW),
    .N_EPROM (N_EPROM)
) u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .host_addr        (host_addr),
    .host_strb        (host_strb),
    .sram_cs          (sram_cs),
    .eprom_cs         (eprom_cs),
    .pstore_cs        (pstore_cs),
    .slave_rst_n      (slave_rst_n),
    .boot_int         (boot_int),
    .pstore_own_slave (pstore_own_slave)
);

// File: tb/boot_map_seq_tb.sv
`timescale 1ns/1ps
module boot_map_seq_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] host_addr = '0;
    logic        host_strb = 1'b0;
    logic        host_we = 1'b0;
    logic [1:0]  host_wdata = '0;
    logic        sram_cs, pstore_cs, slave_rst_n, boot_int, pstore_own_slave;
    logic [1:0]  eprom_cs;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    int unsigned bases[8] = '{32'h000000, 32'h400000, 32'h410000, 32'h420000,
                              32'h800000, 32'h810000, 32'hF00000, 32'hF08000};
    int          offs[7]  = '{0, 1, 32'h7FFF, 32'h8000, 32'hFFFF, 32'h10000, -1};

    always #2 clk = ~clk;

    boot_map_seq u_dut (
        .clk (clk), .rst_n (rst_n), .host_addr (host_addr),
        .host_strb (host_strb), .host_we (host_we), .host_wdata (host_wdata),
        .sram_cs (sram_cs), .eprom_cs (eprom_cs), .pstore_cs (pstore_cs),
        .slave_rst_n (slave_rst_n), .boot_int (boot_int),
        .pstore_own_slave (pstore_own_slave)
    );

    // Expected {sram, eprom1, eprom0, pstore} from the memory map.
    function automatic logic [3:0] exp_cs(logic [23:0] a, bit remapped, bit released, bit strb);
        logic s, e1, e0, p;
        s  = remapped ? (a < 24'h008000) : (a >= 24'hF00000 && a < 24'hF08000);
        e0 = (a >= 24'h400000 && a < 24'h410000);
        e1 = (a >= 24'h410000 && a < 24'h420000);
        p  = !released && (a >= 24'h800000 && a < 24'h810000);
        return strb ? {s, e1, e0, p} : 4'b0000;
    endfunction

    task automatic check_status(string tag, logic e_boot, logic e_run);
        n_checks++;
        if (boot_int !== e_boot || slave_rst_n !== e_run || pstore_own_slave !== e_run) begin
            n_fails++;
            $display("FAIL %s: boot_int/slave_rst_n/own actual %b%b%b expected %b%b%b",
                     tag, boot_int, slave_rst_n, pstore_own_slave, e_boot, e_run, e_run);
        end
    endtask

    task automatic sweep(string tag, bit remapped, bit released, bit strb);
        for (int i = 0; i < 8; i++) begin
            for (int j = 0; j < 7; j++) begin
                logic [23:0] a;
                logic [3:0]  got, want;
                a = 24'(bases[i] + 32'(offs[j]));
                host_addr = a;
                host_strb = strb;
                #0.5;
                got  = {sram_cs, eprom_cs[1], eprom_cs[0], pstore_cs};
                want = exp_cs(a, remapped, released, strb);
                n_checks++;
                if (got !== want) begin
                    n_fails++;
                    $display("FAIL %s: addr %h cs actual %b expected %b", tag, a, got, want);
                end
            end
        end
        host_strb = 1'b0;
    endtask

    task automatic ctrl_write(logic [23:0] a, logic [1:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_strb = 1'b1; host_we = 1'b1;
        @(negedge clk);
        host_we = 1'b0; host_strb = 1'b0; host_wdata = '0;
        #0.5;
    endtask

    task automatic pulse_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        #0.5;
    endtask

    // Watchdog: a hung run counts as one failure.
    initial begin
        #800000;
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check_status("R1", 1'b1, 1'b0);
        rst_n = 1'b1;
        @(negedge clk); #0.5;
        sweep("R9 no-strobe", 1'b0, 1'b0, 1'b0);
        sweep("R2/R3/R5 boot map", 1'b0, 1'b0, 1'b1);

        ctrl_write(24'h810000, 2'b10);          // release before remap
        check_status("R7 release-only", 1'b1, 1'b0);
        sweep("R7 store still host", 1'b0, 1'b0, 1'b1);

        ctrl_write(24'h810001, 2'b11);          // wrong address
        check_status("R8 misaddressed", 1'b1, 1'b0);
        ctrl_write(24'hF00000, 2'b01);
        check_status("R8 misaddressed sram", 1'b1, 1'b0);

        ctrl_write(24'h810000, 2'b11);          // both bits: remap only
        check_status("R4/R7 both bits", 1'b0, 1'b0);
        sweep("R4/R5 loaded map", 1'b1, 1'b0, 1'b1);

        ctrl_write(24'h810000, 2'b00);
        check_status("R8 cleared bits", 1'b0, 1'b0);

        ctrl_write(24'h810000, 2'b10);          // release
        check_status("R6 release", 1'b0, 1'b1);
        sweep("R6/R3 running map", 1'b1, 1'b1, 1'b1);
        ctrl_write(24'h810000, 2'b00);
        check_status("R8 run held", 1'b0, 1'b1);

        pulse_reset();                          // reset from RUN
        check_status("R10 reset from run", 1'b1, 1'b0);
        sweep("R10 boot map after run", 1'b0, 1'b0, 1'b1);

        ctrl_write(24'h810000, 2'b01);
        check_status("R4 remap", 1'b0, 1'b0);
        pulse_reset();                          // reset from LOAD
        check_status("R10 reset from load", 1'b1, 1'b0);
        sweep("R10 boot map after load", 1'b0, 1'b0, 1'b1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule